// File: doc/BRIEF.md
# Fan Monitor Register File and Interrupt Controller

This block is the software-facing register file of a fan-monitor core. A host reaches it through a simple word-wide register port: an address, a write strobe with write data, and a read strobe. The read data is returned one cycle later with a valid flag. The block holds the writable configuration that the PWM and tachometer datapaths consume: the run control, the PWM high time, the expected tach period and the tach tolerance. It also exposes three read-only values that those datapaths produce: the PWM period, the latest tach measurement and the temperature code.

Four single-cycle event pulses arrive from the datapaths, one for each interrupt source. Each pulse is captured in a sticky latch. Software can read the raw latches, or read only the latches that are not masked. It clears latches by writing ones to the pending address. The interrupt output is an active-high level. It stays asserted while any unmasked latch is set.

Top module: `fanmon_regs`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the following hold after that edge: all mask bits are 1, all event latches are 0, `irq_o` is low, `bus_rd_valid` is low, and `run_o`, `duty_o`, `tach_expect_o` and `tach_tol_o` are 0.
- R2: A read strobe in cycle N gives `bus_rd_valid` high in cycle N+1, with `bus_rdata` holding the addressed value. Address 0x00 returns the version word: major in bits 23:16, minor in bits 15:8, patch in bits 7:0 (defaults 1, 0, 0x61, giving 0x00010061).
- R3: Writes to 0x84 (PWM high time), 0x88 (expected tach period) and 0x8C (tach tolerance) store all 32 bits. Writes to 0x80 store only bit 0 as the run control. These values read back and drive their output ports from the cycle after the write. The values do not change without a write.
- R4: Reads of 0xC0, 0xC4 and 0xC8 return `pwm_period_i`, `tach_meas_i` and `temp_code_i`. Writes to these addresses change nothing.
- R5: A 1 on `event_pulse[k]` sets event latch k at the next edge. The bits are: 0 duty changed, 1 tach error, 2 temperature increase, 3 new tach measurement. Address 0x48 reads the raw latches in bits 3:0 whatever the mask is. A latch never sets without its pulse.
- R6: The mask register is at 0x40 and holds bits 3:0. A 1 masks its source. Bits 31:4 are ignored on write and read as 0. Address 0x44 reads the latches that are not masked.
- R7: `irq_o` is high exactly while some latch is set whose mask bit is 0. It follows an event or a mask change in the cycle after the edge that stored it.
- R8: Writing to 0x44 clears each latch whose write-data bit is 1, whatever the mask is. Bits written 0 leave their latch unchanged. No latch clears without such a write.
- R9: If an event pulse and a write-1-to-clear reach the same latch in the same cycle, the latch stays set.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.
- R11: Writes to the source address 0x48 change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | Read data valid, one cycle after bus_rd_en |
| event_pulse | input | NUM_SRC | Single-cycle event pulses, one per interrupt source |
| pwm_period_i | input | DATA_W | PWM period from the PWM datapath |
| tach_meas_i | input | DATA_W | Latest tach measurement |
| temp_code_i | input | DATA_W | Temperature code |
| run_o | output | 1 | Run control for the datapaths |
| duty_o | output | DATA_W | PWM high time |
| tach_expect_o | output | DATA_W | Expected tach period |
| tach_tol_o | output | DATA_W | Tach tolerance |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
A latch stuck set or stuck clear shows up in two places. `irq_o` is wrong one cycle after the event, the mask write or the clear. A read of 0x48 also returns the wrong value one cycle after its strobe. A mask bit with the wrong sense shows as `irq_o` high while the pending read is 0, or the other way round. A wrong priority between an event and a clear in the same cycle shows as a source read of 0 right after that cycle. A decode fault shows as a wrong read-back, or as a configuration output that moves without a write, on the cycle after the access.

// File: rtl/fanmon_pkg.sv
// Package: shared offsets and source indices for the fan-monitor register file.
// Assumes byte addresses of 32-bit words; only offsets that software decodes are fixed here.
package fanmon_pkg;

    localparam logic [7:0] OFF_VERSION = 8'h00;
    localparam logic [7:0] OFF_MASK    = 8'h40;
    localparam logic [7:0] OFF_PEND    = 8'h44;
    localparam logic [7:0] OFF_SRC     = 8'h48;
    localparam logic [7:0] OFF_RUN     = 8'h80;
    localparam logic [7:0] OFF_DUTY    = 8'h84;
    localparam logic [7:0] OFF_TPER    = 8'h88;
    localparam logic [7:0] OFF_TTOL    = 8'h8C;
    localparam logic [7:0] OFF_PPER    = 8'hC0;
    localparam logic [7:0] OFF_TMEAS   = 8'hC4;
    localparam logic [7:0] OFF_TEMP    = 8'hC8;

    // Interrupt source bit positions
    localparam int SRC_DUTY_CHG = 0;
    localparam int SRC_TACH_ERR = 1;
    localparam int SRC_TEMP_UP  = 2;
    localparam int SRC_NEW_MEAS = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VERSION,
        SEL_MASK,
        SEL_PEND,
        SEL_SRC,
        SEL_RUN,
        SEL_DUTY,
        SEL_TPER,
        SEL_TTOL,
        SEL_PPER,
        SEL_TMEAS,
        SEL_TEMP
    } reg_sel_e;

endpackage

// File: rtl/fanmon_addr_dec.sv
// Module: address decoder.
// Maps a byte address to a register select. Any address that does not match
// a word offset exactly, including an unaligned one, maps to SEL_NONE.
module fanmon_addr_dec
    import fanmon_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    // Compare the full address against every known offset
    always_comb begin
        sel_o = SEL_NONE;
        if      (addr_i == ADDR_W'(OFF_VERSION)) sel_o = SEL_VERSION;
        else if (addr_i == ADDR_W'(OFF_MASK))    sel_o = SEL_MASK;
        else if (addr_i == ADDR_W'(OFF_PEND))    sel_o = SEL_PEND;
        else if (addr_i == ADDR_W'(OFF_SRC))     sel_o = SEL_SRC;
        else if (addr_i == ADDR_W'(OFF_RUN))     sel_o = SEL_RUN;
        else if (addr_i == ADDR_W'(OFF_DUTY))    sel_o = SEL_DUTY;
        else if (addr_i == ADDR_W'(OFF_TPER))    sel_o = SEL_TPER;
        else if (addr_i == ADDR_W'(OFF_TTOL))    sel_o = SEL_TTOL;
        else if (addr_i == ADDR_W'(OFF_PPER))    sel_o = SEL_PPER;
        else if (addr_i == ADDR_W'(OFF_TMEAS))   sel_o = SEL_TMEAS;
        else if (addr_i == ADDR_W'(OFF_TEMP))    sel_o = SEL_TEMP;
    end

endmodule

// File: rtl/fanmon_cfg_regs.sv
// Module: writable configuration registers.
// Holds the run bit and three full-width datapath settings. Assumes wr_en is
// already qualified as a bus write strobe.
module fanmon_cfg_regs
    import fanmon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              run_q,
    output logic [DATA_W-1:0] duty_q,
    output logic [DATA_W-1:0] tper_q,
    output logic [DATA_W-1:0] ttol_q
);

    // Run control: only bit 0 is stored
    always_ff @(posedge clk) begin
        if (!rst_n)                       run_q <= 1'b0;
        else if (wr_en && sel_i == SEL_RUN) run_q <= wdata_i[0];
    end

    // PWM high time
    always_ff @(posedge clk) begin
        if (!rst_n)                          duty_q <= '0;
        else if (wr_en && sel_i == SEL_DUTY) duty_q <= wdata_i;
    end

    // Expected tach period
    always_ff @(posedge clk) begin
        if (!rst_n)                          tper_q <= '0;
        else if (wr_en && sel_i == SEL_TPER) tper_q <= wdata_i;
    end

    // Tach tolerance
    always_ff @(posedge clk) begin
        if (!rst_n)                          ttol_q <= '0;
        else if (wr_en && sel_i == SEL_TTOL) ttol_q <= wdata_i;
    end

endmodule

// File: rtl/fanmon_irq_ctrl.sv
// Module: interrupt latches, mask and level output.
// Each source has a sticky latch that its pulse sets and a write-1 clears.
// The pulse wins over a clear in the same cycle. A mask bit of 1 hides its source.
module fanmon_irq_ctrl #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic               mask_wr,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] wbits_i,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] latch_q,
    output logic               irq_o
);

    // Mask register: resets to all sources masked
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= wbits_i;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        // Per-source latch: set has priority over write-1-to-clear
        always_ff @(posedge clk) begin
            if (!rst_n)                    latch_q[k] <= 1'b0;
            else if (event_i[k])           latch_q[k] <= 1'b1;
            else if (clr_wr && wbits_i[k]) latch_q[k] <= 1'b0;
        end
    end

    // Level interrupt from unmasked latches
    always_comb irq_o = |(latch_q & ~mask_q);

endmodule

// File: rtl/fanmon_regs.sv
// Module: fan-monitor register file top.
// Decodes one word access per cycle. A read returns registered data one cycle
// after its strobe. A read and a write in the same cycle see the values before the write.
module fanmon_regs
    import fanmon_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 32,
    parameter int         NUM_SRC   = 4,
    parameter logic [7:0] VER_MAJOR = 8'd1,
    parameter logic [7:0] VER_MINOR = 8'd0,
    parameter logic [7:0] VER_PATCH = 8'h61
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rd_valid,
    input  logic [NUM_SRC-1:0] event_pulse,
    input  logic [DATA_W-1:0]  pwm_period_i,
    input  logic [DATA_W-1:0]  tach_meas_i,
    input  logic [DATA_W-1:0]  temp_code_i,
    output logic               run_o,
    output logic [DATA_W-1:0]  duty_o,
    output logic [DATA_W-1:0]  tach_expect_o,
    output logic [DATA_W-1:0]  tach_tol_o,
    output logic               irq_o
);

    localparam logic [23:0] VERSION_WORD = {VER_MAJOR, VER_MINOR, VER_PATCH};

    reg_sel_e          sel;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] latch_q;
    logic [DATA_W-1:0]  rd_mux;

    fanmon_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    fanmon_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .sel_i   (sel),
        .wdata_i (bus_wdata),
        .run_q   (run_o),
        .duty_q  (duty_o),
        .tper_q  (tach_expect_o),
        .ttol_q  (tach_tol_o)
    );

    fanmon_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (event_pulse),
        .mask_wr (bus_wr_en && sel == SEL_MASK),
        .clr_wr  (bus_wr_en && sel == SEL_PEND),
        .wbits_i (bus_wdata[NUM_SRC-1:0]),
        .mask_q  (mask_q),
        .latch_q (latch_q),
        .irq_o   (irq_o)
    );

    // Read multiplexer; unmapped addresses give zero
    always_comb begin
        case (sel)
            SEL_VERSION: rd_mux = DATA_W'(VERSION_WORD);
            SEL_MASK:    rd_mux = DATA_W'(mask_q);
            SEL_PEND:    rd_mux = DATA_W'(latch_q & ~mask_q);
            SEL_SRC:     rd_mux = DATA_W'(latch_q);
            SEL_RUN:     rd_mux = DATA_W'(run_o);
            SEL_DUTY:    rd_mux = duty_o;
            SEL_TPER:    rd_mux = tach_expect_o;
            SEL_TTOL:    rd_mux = tach_tol_o;
            SEL_PPER:    rd_mux = pwm_period_i;
            SEL_TMEAS:   rd_mux = tach_meas_i;
            SEL_TEMP:    rd_mux = temp_code_i;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read response, zero when no read is returned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd_valid <= 1'b0;
            bus_rdata    <= '0;
        end else begin
            bus_rd_valid <= bus_rd_en;
            bus_rdata    <= bus_rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/fanmon_regs_chk.sv
// Module: property checker bound to fanmon_regs.
// Observes ports and the latch and mask state; drives nothing.
module fanmon_regs_chk #(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic               bus_rd_valid,
    input logic [NUM_SRC-1:0] event_pulse,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] latch_q,
    input logic               irq_o,
    input logic               run_o,
    input logic [DATA_W-1:0]  duty_o
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!irq_o && !bus_rd_valid && latch_q == '0 && mask_q == '1)); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) bus_rd_en |=> bus_rd_valid); // R2

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd_en |=> !bus_rd_valid); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_en |=> ($stable(duty_o) && $stable(run_o))); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n) (event_pulse != '0) |=> ((latch_q & $past(event_pulse)) == $past(event_pulse))); // R5

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(event_pulse)) == '0)); // R5

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_en |=> ((~latch_q & $past(latch_q)) == '0)); // R8

    AST_UNMASKED_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (((event_pulse & ~mask_q) != '0) && !bus_wr_en) |=> irq_o); // R7

endmodule

bind fanmon_regs fanmon_regs_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_rd_valid (bus_rd_valid),
    .event_pulse  (event_pulse),
    .mask_q       (mask_q),
    .latch_q      (latch_q),
    .irq_o        (irq_o),
    .run_o        (run_o),
    .duty_o       (duty_o)
);

// File: tb/fanmon_regs_test.sv
// Bench: walks a vector table of register accesses, then runs directed tests
// for interrupt latching, masking, clearing, collisions and reset.
module fanmon_regs_test;

    localparam logic [31:0] PPER  = 32'h0000_03E8;
    localparam logic [31:0] TMEAS = 32'h0001_2345;
    localparam logic [31:0] TEMPC = 32'h0000_9ABC;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h40, 32'h0000_000F, 8'd1},   // R1 mask resets to all ones
        '{1'b0, 8'h48, 32'h0000_0000, 8'd1},   // R1 latches clear
        '{1'b0, 8'h00, 32'h0001_0061, 8'd2},   // R2 version word
        '{1'b1, 8'h84, 32'hDEAD_BEEF, 8'd3},
        '{1'b0, 8'h84, 32'hDEAD_BEEF, 8'd3},   // R3
        '{1'b1, 8'h88, 32'h0001_2000, 8'd3},
        '{1'b0, 8'h88, 32'h0001_2000, 8'd3},   // R3
        '{1'b1, 8'h8C, 32'h0000_0480, 8'd3},
        '{1'b0, 8'h8C, 32'h0000_0480, 8'd3},   // R3
        '{1'b1, 8'h80, 32'hFFFF_FFFF, 8'd3},
        '{1'b0, 8'h80, 32'h0000_0001, 8'd3},   // R3 only bit 0 kept
        '{1'b0, 8'hC0, PPER,          8'd4},   // R4
        '{1'b1, 8'hC0, 32'h0000_0000, 8'd4},
        '{1'b0, 8'hC0, PPER,          8'd4},   // R4 write ignored
        '{1'b0, 8'hC4, TMEAS,         8'd4},   // R4
        '{1'b0, 8'hC8, TEMPC,         8'd4},   // R4
        '{1'b1, 8'h40, 32'hFFFF_FFF0, 8'd6},
        '{1'b0, 8'h40, 32'h0000_0000, 8'd6},   // R6 upper bits ignored
        '{1'b0, 8'h50, 32'h0000_0000, 8'd10},  // R10 unmapped reads zero
        '{1'b1, 8'h50, 32'h1234_5678, 8'd10},
        '{1'b0, 8'h84, 32'hDEAD_BEEF, 8'd10},  // R10 unmapped write touched nothing
        '{1'b0, 8'h44, 32'h0000_0000, 8'd6}    // R6 nothing pending
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rd_valid;
    logic [3:0]  event_pulse = '0;
    logic        run_o;
    logic [31:0] duty_o;
    logic [31:0] tach_expect_o;
    logic [31:0] tach_tol_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fanmon_regs uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr_en     (bus_wr_en),
        .bus_rd_en     (bus_rd_en),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_rd_valid  (bus_rd_valid),
        .event_pulse   (event_pulse),
        .pwm_period_i  (PPER),
        .tach_meas_i   (TMEAS),
        .temp_code_i   (TEMPC),
        .run_o         (run_o),
        .duty_o        (duty_o),
        .tach_expect_o (tach_expect_o),
        .tach_tol_o    (tach_tol_o),
        .irq_o         (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        event_pulse = e;
        @(negedge clk);
        event_pulse = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] got;
        repeat (4) @(negedge clk);
        // R1 reset state at the ports
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 run_o", {31'b0, run_o}, 32'h0);
        check("R1 duty_o", duty_o, 32'h0);
        check("R1 tach_tol_o", tach_tol_o, 32'h0);
        check("R1 rd_valid", {31'b0, bus_rd_valid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
            else begin
                do_read(VEC[i].addr, got);
                check($sformatf("R%0d vec %0d", VEC[i].req, i), got, VEC[i].data);
            end
        end

        // R2 read latency: valid one cycle after strobe, then drops
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = 8'h88;
        @(negedge clk);
        bus_rd_en = 1'b0;
        check("R2 valid after strobe", {31'b0, bus_rd_valid}, 32'h1);
        check("R2 data", bus_rdata, 32'h0001_2000);
        @(negedge clk);
        check("R2 valid drops", {31'b0, bus_rd_valid}, 32'h0);

        // R3 outputs follow the written values
        check("R3 duty_o", duty_o, 32'hDEAD_BEEF);
        check("R3 run_o", {31'b0, run_o}, 32'h1);
        check("R3 tach_expect_o", tach_expect_o, 32'h0001_2000);

        // R5/R7: temperature-increase event, all sources enabled
        pulse(4'b0100);
        check("R7 irq after event", {31'b0, irq_o}, 32'h1);
        do_read(8'h48, got); check("R5 source", got, 32'h4);
        do_read(8'h44, got); check("R6 pending", got, 32'h4);

        // R6/R7: mask bit 2 hides the source but not the raw latch
        do_write(8'h40, 32'h0000_0004);
        check("R7 irq masked", {31'b0, irq_o}, 32'h0);
        do_read(8'h44, got); check("R6 pending masked", got, 32'h0);
        do_read(8'h48, got); check("R5 source ignores mask", got, 32'h4);

        // R11: source address is read-only
        do_write(8'h48, 32'h0000_000F);
        do_read(8'h48, got); check("R11 source write ignored", got, 32'h4);

        // R8: zeros leave latches alone, ones clear even while masked
        do_write(8'h44, 32'h0000_0003);
        do_read(8'h48, got); check("R8 zero bit keeps latch", got, 32'h4);
        do_write(8'h44, 32'h0000_0004);
        do_read(8'h48, got); check("R8 clear while masked", got, 32'h0);
        do_write(8'h40, 32'h0000_0000);
        check("R7 irq after unmask empty", {31'b0, irq_o}, 32'h0);

        // R9: event and clear on the same latch in one cycle
        pulse(4'b0010);
        @(negedge clk);
        event_pulse = 4'b0010; bus_wr_en = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h2;
        @(negedge clk);
        event_pulse = '0; bus_wr_en = 1'b0;
        check("R9 irq held", {31'b0, irq_o}, 32'h1);
        do_read(8'h48, got); check("R9 event wins", got, 32'h2);
        // R9 other bit: event on bit 0 while bit 1 is cleared
        @(negedge clk);
        event_pulse = 4'b0001; bus_wr_en = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h2;
        @(negedge clk);
        event_pulse = '0; bus_wr_en = 1'b0;
        do_read(8'h48, got); check("R9 split set and clear", got, 32'h1);
        do_write(8'h44, 32'h0000_000F);
        check("R7 irq after clear all", {31'b0, irq_o}, 32'h0);

        // R7: two sources, mask one then both
        pulse(4'b1001);
        do_read(8'h48, got); check("R5 two sources", got, 32'h9);
        do_write(8'h40, 32'h0000_0008);
        check("R7 one unmasked left", {31'b0, irq_o}, 32'h1);
        do_write(8'h40, 32'h0000_0009);
        check("R7 all set sources masked", {31'b0, irq_o}, 32'h0);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 run_o after reset", {31'b0, run_o}, 32'h0);
        check("R1 duty_o after reset", duty_o, 32'h0);
        do_read(8'h40, got); check("R1 mask after reset", got, 32'hF);
        do_read(8'h48, got); check("R1 latches after reset", got, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule